// File: doc/BRIEF.md
# Clocked Serial Transmitter with Idle-Output Control

This block is one transmit channel of a synchronous serial port. A byte written to it is sent LSB first on a serial data pin. The bit clock comes from one of two places. It can be made inside the block by dividing the system clock with an 8-bit rate value. It can also come from outside on an input pin, in which case the block follows its edges.

The data pin behaves in one of two ways once the byte is done. It can float, so that another talker can share the line. It can also keep driving the last bit. The hold choice counts only when the block makes its own clock, and the block captures it at the moment the channel is switched on.

The state machine has five states:

- `ST_IDLE`: no transfer is running.
- `ST_INT_LOW` and `ST_INT_HIGH`: the two halves of a bit with the internal clock.
- `ST_EXT_HIGH` and `ST_EXT_LOW`: waiting for a falling or a rising edge of the external clock.

It has these transitions:

- *start*: `ST_IDLE` to `ST_INT_LOW` or to `ST_EXT_HIGH`.
- *half-done*: `ST_INT_LOW` to `ST_INT_HIGH`.
- *next-bit*: `ST_INT_HIGH` to `ST_INT_LOW`, with a shift.
- *ext-fall*: `ST_EXT_HIGH` to `ST_EXT_LOW`. It shifts on every bit except the first.
- *ext-rise*: `ST_EXT_LOW` to `ST_EXT_HIGH`.
- *finish*: the eighth high half, or the eighth external rise, back to `ST_IDLE`.
- *abort*: any state to `ST_IDLE` when the channel is disabled.

Top module: `sio_tx_channel`

## Requirements
- R1: With the internal clock and rate value n, each low half and each high half of `sclk_out` lasts n+1 clock cycles, so `busy` stays high for 16·(n+1) cycles.
- R2: Bits leave LSB first. `sdo` changes only as `sclk_out` falls and holds steady while it is high. `sclk_out` is 1 whenever the channel is not busy.
- R3: A `tx_wr` pulse starts a transfer only when the channel is enabled and `busy` is 0. A pulse at any other time is ignored. `busy` rises one cycle after the accepted pulse and falls when the eighth bit ends.
- R4: A rate write (`div_wr`) while `busy` is 1 is dropped. The running transfer and the next one both keep the old rate. The rate value cannot be read back.
- R5: With the internal clock and hold = 1, `sdo_oe` stays 1 after the transfer and `sdo` keeps bit 7 of the byte sent.
- R6: With hold = 0, `sdo_oe` goes to 0 when `busy` falls.
- R7: With the external clock, one bit is sent per external falling/rising pair, and `sdo_oe` goes to 0 after the transfer even when hold = 1.
- R8: The hold and clock-select values are captured only on a control write that raises the enable from 0 to 1. A control write made while the channel is already enabled has no effect on them.
- R9: After reset the channel is disabled with hold = 0, rate = 0, `busy` = 0, `sdo_oe` = 0 and `sclk_out` = 1.
- R10: `sdo_oe` is 1 throughout every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it is also the count source of the divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Channel enable value |
| ctrl_ext_clk | input | 1 | Clock select value: 1 = external clock, 0 = internal clock |
| ctrl_hold_last | input | 1 | Output state after a transfer: 1 = keep the last bit, 0 = float |
| div_wr | input | 1 | Rate write strobe |
| div_val | input | 8 | Rate value n; the bit clock runs at clk/(2·(n+1)) |
| tx_wr | input | 1 | Transmit data write strobe; it starts a transfer |
| tx_data | input | 8 | Byte to send |
| ext_sclk | input | 1 | External serial clock, asynchronous to `clk` |
| sclk_out | output | 1 | Internally generated serial clock; it idles high |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Output enable for `sdo`; 1 = driven, 0 = high-impedance |
| busy | output | 1 | High while a transfer is running |

## Verification
The bench measures every half-period of the internal clock, including at rate 0. A divider that is off by one, or a clock that does not restart cleanly, shows up as a wrong run length or a wrong total `busy` length. The bench also changes the rate and writes a second byte in the middle of a transfer. A design that does not freeze its rate then stretches its bit times, and a design that reloads its shifter on a busy write corrupts the byte.

The bench checks the pin state after the transfer in both clock modes and with both hold values. It sends bytes whose last bit is 0 and bytes whose last bit is 1. This catches a design that floats when it should hold, or holds in external mode. It also catches one that shifts once too often and so drives a 0 in place of bit 7. A further test changes the hold bit while the channel is enabled. A design that does not capture the hold bit at enable then follows the late write.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT_LOW,
        ST_INT_HIGH,
        ST_EXT_HIGH,
        ST_EXT_LOW
    } sio_state_e;
endpackage

// File: rtl/sio_rate_div.sv
module sio_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    // The chain resets high to match the idle level of the serial clock.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/sio_shift_fsm.sv
module sio_shift_fsm
    import sio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ext_mode,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic              tick,
    input  logic              ext_rise,
    input  logic              ext_fall,
    output logic              busy,
    output logic              int_run,
    output logic              sclk,
    output logic              sdo,
    output logic              done
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    sio_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              load, shift, cnt_inc;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and datapath controls
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        shift   = 1'b0;
        cnt_inc = 1'b0;
        done    = 1'b0;
        if (!enable) begin
            state_d = ST_IDLE;                         // abort
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin              // start
                    load    = 1'b1;
                    state_d = ext_mode ? ST_EXT_HIGH : ST_INT_LOW;
                end
                ST_INT_LOW: if (tick) state_d = ST_INT_HIGH;   // half-done
                ST_INT_HIGH: if (tick) begin
                    if (bit_cnt_q == LAST_BIT) begin   // finish
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin                     // next-bit
                        shift   = 1'b1;
                        cnt_inc = 1'b1;
                        state_d = ST_INT_LOW;
                    end
                end
                ST_EXT_HIGH: if (ext_fall) begin       // ext-fall
                    shift   = (bit_cnt_q != '0);
                    state_d = ST_EXT_LOW;
                end
                ST_EXT_LOW: if (ext_rise) begin
                    if (bit_cnt_q == LAST_BIT) begin   // finish
                        done    = 1'b1;
                        state_d = ST_IDLE;
                    end else begin                     // ext-rise
                        cnt_inc = 1'b1;
                        state_d = ST_EXT_HIGH;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
        end else if (load) begin
            shreg_q   <= load_data;
            bit_cnt_q <= '0;
        end else begin
            if (shift)   shreg_q   <= {1'b0, shreg_q[DATA_W-1:1]};
            if (cnt_inc) bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        int_run = (state_q == ST_INT_LOW) || (state_q == ST_INT_HIGH);
        sclk    = (state_q != ST_INT_LOW);
        sdo     = shreg_q[0];
    end
endmodule

// File: rtl/sio_tx_channel.sv
module sio_tx_channel #(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_enable,
    input  logic              ctrl_ext_clk,
    input  logic              ctrl_hold_last,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_val,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              ext_sclk,
    output logic              sclk_out,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy
);
    logic             en_q, ext_lat, hold_lat, held_q;
    logic [DIV_W-1:0] div_q;
    logic             start, tick, int_run, done, ext_rise, ext_fall, sclk_int;

    assign start = tx_wr && en_q && !busy;

    // Control: mode and hold are captured only when the enable rises.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ext_lat  <= 1'b0;
            hold_lat <= 1'b0;
        end else if (ctrl_wr) begin
            en_q <= ctrl_enable;
            if (ctrl_enable && !en_q) begin
                ext_lat  <= ctrl_ext_clk;
                hold_lat <= ctrl_hold_last;
            end
        end
    end

    // Rate value: write-only, and frozen while a transfer runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_q <= '0;
        else if (div_wr && !busy)  div_q <= div_val;
    end

    // The pin keeps driving after a finished internal-clock transfer with hold set.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            held_q <= 1'b0;
        else if (!en_q || start)               held_q <= 1'b0;
        else if (done && hold_lat && !ext_lat) held_q <= 1'b1;
    end

    sio_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(int_run), .limit(div_q), .tick(tick)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_sclk), .rise(ext_rise), .fall(ext_fall)
    );

    sio_shift_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(en_q), .ext_mode(ext_lat),
        .start(start), .load_data(tx_data), .tick(tick),
        .ext_rise(ext_rise), .ext_fall(ext_fall),
        .busy(busy), .int_run(int_run), .sclk(sclk_int), .sdo(sdo), .done(done)
    );

    assign sclk_out = sclk_int;
    assign sdo_oe   = busy | held_q;
endmodule

// File: rtl/sio_tx_checker.sv
module sio_tx_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             sclk_out,
    input logic             sdo,
    input logic             sdo_oe,
    input logic             en_q,
    input logic             ext_lat,
    input logic             hold_lat,
    input logic [DIV_W-1:0] div_q
);
    p_idle_clock_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    p_data_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk_out && !ext_lat && $past(busy) && $past(sclk_out)) |-> $stable(sdo));

    p_disable_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !busy);

    p_rate_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));

    p_float_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !hold_lat) |-> !sdo_oe);

    p_float_external_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && ext_lat) |-> !sdo_oe);

    p_drive_in_transfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> sdo_oe);
endmodule

bind sio_tx_channel sio_tx_checker #(.DIV_W(DIV_W)) u_sio_tx_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .sclk_out(sclk_out), .sdo(sdo),
    .sdo_oe(sdo_oe), .en_q(en_q), .ext_lat(ext_lat), .hold_lat(hold_lat), .div_q(div_q)
);

// File: tb/test_sio_tx_channel.sv
module test_sio_tx_channel;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 0, ctrl_enable = 0, ctrl_ext_clk = 0, ctrl_hold_last = 0;
    logic       div_wr = 0, tx_wr = 0, ext_sclk = 1;
    logic [7:0] div_val = 0, tx_data = 0;
    logic       sclk_out, sdo, sdo_oe, busy;
    int         errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    sio_tx_channel i_sio_tx_channel (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
        .ctrl_ext_clk(ctrl_ext_clk), .ctrl_hold_last(ctrl_hold_last),
        .div_wr(div_wr), .div_val(div_val), .tx_wr(tx_wr), .tx_data(tx_data),
        .ext_sclk(ext_sclk), .sclk_out(sclk_out), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy)
    );

    // {hold, rate, data}
    localparam logic [16:0] VEC [5] = '{
        {1'b1, 8'd0, 8'hA5}, {1'b0, 8'd2, 8'h3C}, {1'b1, 8'd1, 8'h80},
        {1'b1, 8'd3, 8'h01}, {1'b0, 8'd0, 8'hFF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input bit en, input bit ext, input bit hold);
        ctrl_enable = en; ctrl_ext_clk = ext; ctrl_hold_last = hold; ctrl_wr = 1;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic configure(input bit ext, input bit hold);
        ctrl_write(0, 0, 0);
        ctrl_write(1, ext, hold);
    endtask

    task automatic write_div(input logic [7:0] v);
        div_val = v; div_wr = 1;
        @(negedge clk); div_wr = 0;
    endtask

    // Sends one byte with the internal clock and measures it at the pins.
    task automatic run_int(input logic [7:0] d, input int n, input bit mid_div, input bit mid_tx,
                           output logic [7:0] cap, output int cyc, output int bad, output int rises);
        logic prev;
        int   run;
        tx_data = d; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
        cap = 0; cyc = 0; bad = 0; rises = 0; run = 0; prev = sclk_out;
        while (busy === 1'b1 && cyc < 5000) begin
            div_wr = (mid_div && cyc == 3);
            div_val = 8'd5;
            tx_wr = (mid_tx && cyc == 5);
            if (mid_tx && cyc == 5) tx_data = ~d;
            if (sclk_out !== prev) begin
                if (run != n + 1) bad++;
                if (sclk_out && rises < 8) begin cap[rises] = sdo; rises++; end
                run = 0;
            end
            run++; cyc++; prev = sclk_out;
            @(negedge clk);
        end
        div_wr = 0; tx_wr = 0;
        if (run != n + 1) bad++;
    endtask

    task automatic run_ext(input logic [7:0] d, output logic [7:0] cap);
        tx_data = d; tx_wr = 1;
        @(negedge clk); tx_wr = 0;
        cap = 0;
        for (int i = 0; i < 8; i++) begin
            ext_sclk = 0; repeat (6) @(negedge clk);
            cap[i] = sdo;
            ext_sclk = 1; repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] cap;
        int cyc, bad, rises;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check(busy == 0 && sdo_oe == 0 && sclk_out == 1, "R9 reset outputs",
              {busy, sdo_oe, sclk_out}, 3'b001);
        tx_data = 8'h55; tx_wr = 1; @(negedge clk); tx_wr = 0; @(negedge clk);
        check(busy == 0, "R9/R3 disabled after reset ignores start", busy, 0);

        // Table walk: R1, R2, R3, R5, R6, R10
        foreach (VEC[k]) begin
            configure(0, VEC[k][16]);
            write_div(VEC[k][15:8]);
            run_int(VEC[k][7:0], int'(VEC[k][15:8]), 0, 0, cap, cyc, bad, rises);
            check(cap == VEC[k][7:0] && rises == 8, "R2 byte LSB first", cap, VEC[k][7:0]);
            check(cyc == 16 * (int'(VEC[k][15:8]) + 1), "R1/R3 busy length", cyc,
                  16 * (int'(VEC[k][15:8]) + 1));
            check(bad == 0, "R1 half-period length", bad, 0);
            check(sclk_out == 1, "R2 clock idles high", sclk_out, 1);
            if (VEC[k][16])
                check(sdo_oe == 1 && sdo == VEC[k][7], "R5 hold last bit",
                      {sdo_oe, sdo}, {1'b1, VEC[k][7]});
            else
                check(sdo_oe == 0, "R6 float after transfer", sdo_oe, 0);
        end

        // R4 rate write and R3 data write during a transfer are ignored
        configure(0, 0);
        write_div(8'd1);
        run_int(8'h6B, 1, 1, 1, cap, cyc, bad, rises);
        check(cap == 8'h6B, "R3 busy data write ignored", cap, 8'h6B);
        check(cyc == 32 && bad == 0, "R4 rate unchanged in transfer", cyc, 32);
        run_int(8'h92, 1, 0, 0, cap, cyc, bad, rises);
        check(cyc == 32 && bad == 0, "R4 rate unchanged next transfer", cyc, 32);
        check(cap == 8'h92, "R2 byte after ignored writes", cap, 8'h92);

        // R3 start ignored when disabled
        ctrl_write(0, 0, 0);
        tx_data = 8'h11; tx_wr = 1; @(negedge clk); tx_wr = 0;
        repeat (3) @(negedge clk);
        check(busy == 0 && sdo_oe == 0, "R3 disabled ignores start", busy, 0);

        // R8 hold written while enabled has no effect
        configure(0, 0);
        ctrl_write(1, 0, 1);
        write_div(8'd0);
        run_int(8'hC1, 0, 0, 0, cap, cyc, bad, rises);
        check(sdo_oe == 0, "R8 late hold write ignored", sdo_oe, 0);
        configure(0, 1);
        run_int(8'hC1, 0, 0, 0, cap, cyc, bad, rises);
        check(sdo_oe == 1 && sdo == 1, "R8 hold taken at enable", {sdo_oe, sdo}, 2'b11);
        tx_data = 8'h02; tx_wr = 1; @(negedge clk); tx_wr = 0;
        check(busy == 1 && sdo == 0, "R10/R2 new transfer drives bit 0", {busy, sdo}, 2'b10);
        repeat (20) @(negedge clk);

        // R7 external clock, hold requested but pin floats
        configure(1, 1);
        run_ext(8'hC6, cap);
        check(cap == 8'hC6, "R7 external clock byte", cap, 8'hC6);
        check(busy == 0 && sdo_oe == 0, "R7 float after external transfer",
              {busy, sdo_oe}, 2'b00);
        check(sclk_out == 1, "R2 internal clock idle in external mode", sclk_out, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule